// File: doc/BRIEF.md
# Phase-Accumulator Sine Tone Generator

This block synthesizes a digital sine tone by direct digital synthesis. A wide unsigned phase accumulator advances by a programmable tuning word on every enabled clock and wraps freely modulo 2^N. Its four most significant bits select one of sixteen signed samples covering one full sine period. The selected sample is registered onto an 8-bit two's-complement output. The tone frequency is F = M · Fclk / 2^N. With N = 32, the step is fine enough for sub-hertz resolution at a 100 MHz clock.

The lower accumulator bits give no output directly. They carry the fractional phase, so that a tuning word that is not a multiple of 2^(N-4) still produces the correct average frequency. Software or a neighbouring block drives the tuning word. It may be changed on any cycle, and the new value is used on the next accumulation.

Top module: `dds_tone`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator and the sample, so that after that edge sample = 0 and phase_idx = 0.
- R2: On each rising edge with en high and rst low, the accumulator becomes (accumulator + tune) mod 2^ACC_W. phase_idx always shows accumulator bits [ACC_W-1:ACC_W-4].
- R3: Accumulation wraps modulo 2^ACC_W with no saturation. A tuning word of 2^ACC_W − 1 therefore walks the phase backwards by one least significant step per clock.
- R4: On each enabled edge, sample takes the table entry selected by the phase_idx value present before that edge, which gives one cycle of latency. The table, indexed 0 to 15, holds the signed decimal values 0, 24, 45, 59, 64, 59, 45, 24, 0, −24, −45, −59, −64, −59, −45, −24.
- R5: With en low and rst low, an edge leaves both sample and phase_idx unchanged.
- R6: tune is sampled at every enabled edge. A new value applied before an edge is used at that edge, with no pipeline delay.
- R7: With ACC_W = 4 and tune = 1 held, phase_idx steps through 0 to 15 and the sample sequence repeats exactly every 16 enabled clocks.
- R8: sample always lies within −64 to +64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, all state holds |
| tune | input | ACC_W | Unsigned tuning word added per enabled clock |
| sample | output | 8 | Registered signed sine sample |
| phase_idx | output | 4 | Top four accumulator bits, the current table index |

## Verification
A one-index-per-clock tuning word walks the table in order, which exposes any misordered or wrong table entry and the one-cycle sample latency. Triple steps, fractional steps of 3/4 of an index and an all-ones word show whether the fractional bits carry correctly into the index and whether wraparound runs backwards without saturating. A stuttering enable pattern and a tuning word that changes on every cycle show hold behaviour and same-edge use of tune. A second instance, 4 bits wide with a unit step, checks the degenerate 16-clock period.

// File: rtl/dds_tone.sv
module dds_tone #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune,
  output logic signed [7:0]       sample,
  output logic [3:0]              phase_idx
);

  localparam int IDX_W = 4;

  logic [ACC_W-1:0] acc;

  function automatic logic signed [7:0] sine_lut(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return 8'sh00;
      4'd1:  return 8'sh18;
      4'd2:  return 8'sh2D;
      4'd3:  return 8'sh3B;
      4'd4:  return 8'sh40;
      4'd5:  return 8'sh3B;
      4'd6:  return 8'sh2D;
      4'd7:  return 8'sh18;
      4'd8:  return 8'sh00;
      4'd9:  return 8'shE8;
      4'd10: return 8'shD3;
      4'd11: return 8'shC5;
      4'd12: return 8'shC0;
      4'd13: return 8'shC5;
      4'd14: return 8'shD3;
      default: return 8'shE8;
    endcase
  endfunction

  assign phase_idx = acc[ACC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      sample <= '0;
    end else if (en) begin
      acc    <= acc + tune;
      sample <= sine_lut(phase_idx);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sample == 8'sd0 && phase_idx == '0));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sample) && $stable(phase_idx)));

  // R4
  lut_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> (sample == sine_lut($past(phase_idx))));

  // R8
  amp_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($signed(sample) <= 64 && $signed(sample) >= -64));

endmodule

// File: tb/test_dds_tone.sv
`timescale 1ns/1ps
module test_dds_tone;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] tune = '0;
  logic signed [7:0] sample, sample4;
  logic [3:0]  phase_idx, phase_idx4;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;
  string cur_req = "R1";

  int tab [16] = '{0, 24, 45, 59, 64, 59, 45, 24, 0, -24, -45, -59, -64, -59, -45, -24};
  longint macc = 0;
  int     msamp = 0;
  int     macc4 = 0;
  int     msamp4 = 0;

  always #2 clk = ~clk;

  dds_tone #(.ACC_W(32)) i_dds_tone (
    .clk(clk), .rst(rst), .en(en), .tune(tune),
    .sample(sample), .phase_idx(phase_idx));

  dds_tone #(.ACC_W(4)) i_dds_tone_n4 (
    .clk(clk), .rst(rst), .en(en), .tune(4'd1),
    .sample(sample4), .phase_idx(phase_idx4));

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      macc = 0; msamp = 0; macc4 = 0; msamp4 = 0;
    end else if (en) begin
      msamp  = tab[int'(macc >> 28)];
      macc   = (macc + longint'(tune)) % 64'h1_0000_0000;
      msamp4 = tab[macc4];
      macc4  = (macc4 + 1) % 16;
    end
    @(negedge clk);
    check(cur_req, "sample", int'(sample), msamp);
    check(cur_req, "phase_idx", int'(phase_idx), int'(macc >> 28));
    check("R7", "sample4", int'(sample4), msamp4);
    check("R7", "phase_idx4", int'(phase_idx4), macc4);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    repeat (3) tick();
    rst = 1'b0;
    en = 1'b1;
    cur_req = "R4";
    tune = 32'h1000_0000;
    repeat (40) tick();
    cur_req = "R2";
    tune = 32'h3000_0000;
    repeat (20) tick();
    tune = 32'h0C00_0000;
    repeat (40) tick();
    cur_req = "R3";
    tune = 32'hFFFF_FFFF;
    repeat (30) tick();
    tune = 32'hF000_0001;
    repeat (30) tick();
    cur_req = "R5";
    tune = 32'h1000_0000;
    for (int i = 0; i < 45; i++) begin
      en = (i % 3) != 0;
      tick();
    end
    en = 1'b1;
    cur_req = "R6";
    for (int i = 0; i < 60; i++) begin
      tune = 32'(i) * 32'h1357_9BDF;
      tick();
    end
    cur_req = "R1";
    rst = 1'b1;
    tick();
    rst = 1'b0;
    cur_req = "R7";
    tune = 32'h1000_0000;
    repeat (48) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule